// File: doc/BRIEF.md
# Word-Oriented Accumulator Processor

This block is a small multicycle processor for a 24-bit accumulator machine. It reads 24-bit instructions from a byte-addressed memory, one byte per cycle. It executes word loads and stores, signed integer arithmetic, a signed compare that drives three conditional jumps, an unconditional jump, subroutine call and return through a link register, and byte-wide device I/O on the low byte of the accumulator. The machine has three programmer-visible registers: the accumulator A, the index register X and the link register L. It also has a two-state-plus-one condition code and a 15-bit program counter.

The memory port drives one byte address per cycle. Read data is valid in the same cycle the address is driven, and a write takes effect at the rising clock edge while the write enable is high. A word is three bytes, stored with the most significant byte at the lowest address. The device port carries an 8-bit device code, a ready flag, a read byte, a write byte and one-cycle read and write strobes. The processor stops and raises `halted` on an unknown opcode or on a divide by zero.

The control is one state machine with these states:
- FETCH reads three instruction bytes and then moves to DECODE.
- DECODE forms the target address. It then goes to LOADW for loads, arithmetic and compare, to STOREW for stores, back to FETCH for jumps, to DEVIO for device instructions, and to HALT for unknown opcodes.
- LOADW reads three operand bytes and then moves to APPLY.
- APPLY writes the result or the condition code and returns to FETCH. On a zero divisor it goes to HALT instead.
- STOREW writes three bytes and returns to FETCH.
- DEVIO performs the device access in one cycle and returns to FETCH.
- HALT is never left until reset.

Top module: `acc24_cpu`

## Requirements
- R1: While reset (rst_n low, synchronous) is held, the machine does the following: mem_addr is 0, mem_we, dev_rd_stb, dev_wr_stb and halted are 0, and A, X, L, PC and the condition code are cleared.
- R2: After reset the first instruction is read from addresses 0, 1, 2 in consecutive cycles. The byte at the lowest address is the opcode. The PC then advances by 3. The opcode values are LDA 00, LDX 04, STA 0C, STX 10, ADD 18, SUB 1C, MUL 20, DIV 24, COMP 28, JEQ 30, JGT 34, JLT 38, J 3C, JSUB 48, RSUB 4C, RD D8, WD DC and TD E0 (hex).
- R3: Instruction bit 15 is the index flag. When it is 1, the target address is bits 14:0 plus the low 15 bits of X, modulo 32768. Otherwise the target address is bits 14:0.
- R4: LDA/LDX load A/X from the three bytes at the target address, most significant byte first. STA/STX write A/X as three single-cycle writes to consecutive ascending addresses, most significant byte first.
- R5: ADD, SUB and MUL combine A with the memory word and place the low 24 bits of the two's-complement result in A.
- R6: DIV replaces A with the signed quotient A / word, truncated toward zero. When the word is zero, the processor halts and no later instruction runs.
- R7: COMP sets the condition code to less, equal or greater by a signed comparison of A with the word. JLT, JEQ and JGT jump to the target only on the matching code. J always jumps.
- R8: JSUB stores the address of the following instruction in L and jumps to the target. RSUB jumps to the address held in L.
- R9: TD sets the condition code to less when dev_ready is 1 and to equal when dev_ready is 0.
- R10: For TD, RD and WD, dev_code is the memory byte at the target address. RD puts dev_rdata into A bits 7:0 and keeps A bits 23:8. WD presents A bits 7:0 on dev_wdata. Each strobe lasts one cycle and never coincides with a memory write.
- R11: An unknown opcode raises halted. From then on halted stays high, and no memory write or device strobe happens until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 15 | Byte address of the current memory access |
| mem_rdata | input | 8 | Byte read at mem_addr, valid in the same cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable, one byte per cycle |
| dev_code | output | 8 | Code of the addressed device |
| dev_ready | input | 1 | Addressed device is ready |
| dev_rdata | input | 8 | Byte supplied by the device on a read |
| dev_wdata | output | 8 | Byte sent to the device on a write |
| dev_rd_stb | output | 1 | One-cycle read strobe |
| dev_wr_stb | output | 1 | One-cycle write strobe |
| halted | output | 1 | Processor has stopped |

## Verification
In DEVIO the device code is read from memory in the same cycle that the strobe fires or the condition code is set. In DECODE the link write and the jump to the target also coincide. A program calls an indexed summing subroutine and then polls a device with TD until it becomes ready. It then writes the low byte of the sum and reads a byte back. The program is run once with the device ready from the start and once with readiness held off past the end of the call. The results are judged by the byte, the code and the cycle the device model latched, and by the words stored afterwards. A sweep over all pairs from a set of signed operands checks the arithmetic, the compare-driven jumps and the zero-divisor halt against values computed in the bench.

// File: rtl/acc24_pkg.sv
package acc24_pkg;

    typedef enum logic [7:0] {
        OP_LDA  = 8'h00, OP_LDX = 8'h04, OP_STA  = 8'h0C, OP_STX  = 8'h10,
        OP_ADD  = 8'h18, OP_SUB = 8'h1C, OP_MUL  = 8'h20, OP_DIV  = 8'h24,
        OP_COMP = 8'h28, OP_JEQ = 8'h30, OP_JGT  = 8'h34, OP_JLT  = 8'h38,
        OP_J    = 8'h3C, OP_JSUB = 8'h48, OP_RSUB = 8'h4C,
        OP_RD   = 8'hD8, OP_WD  = 8'hDC, OP_TD   = 8'hE0
    } opcode_e;

    typedef enum logic [1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10
    } cc_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_LOADW, ST_APPLY, ST_STOREW, ST_DEVIO, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        CL_LOAD, CL_STORE, CL_JUMP, CL_DEV, CL_BAD
    } opclass_e;

    typedef enum logic [2:0] {
        AL_PASS, AL_ADD, AL_SUB, AL_MUL, AL_DIV
    } aluop_e;

endpackage

// File: rtl/acc24_decode.sv
module acc24_decode
    import acc24_pkg::*;
#(
    parameter int OPC_W = 8
) (
    input  logic [OPC_W-1:0] opc,
    input  cc_e              cc,
    output opclass_e         cls,
    output aluop_e           aop,
    output logic             sel_x,
    output logic             is_cmp,
    output logic             take,
    output logic             link,
    output logic             ret
);
    always_comb begin
        cls    = CL_BAD;
        aop    = AL_PASS;
        sel_x  = 1'b0;
        is_cmp = 1'b0;
        take   = 1'b0;
        link   = 1'b0;
        ret    = 1'b0;
        unique case (opc)
            OP_LDA:  cls = CL_LOAD;
            OP_LDX:  begin cls = CL_LOAD;  sel_x = 1'b1; end
            OP_STA:  cls = CL_STORE;
            OP_STX:  begin cls = CL_STORE; sel_x = 1'b1; end
            OP_ADD:  begin cls = CL_LOAD;  aop = AL_ADD; end
            OP_SUB:  begin cls = CL_LOAD;  aop = AL_SUB; end
            OP_MUL:  begin cls = CL_LOAD;  aop = AL_MUL; end
            OP_DIV:  begin cls = CL_LOAD;  aop = AL_DIV; end
            OP_COMP: begin cls = CL_LOAD;  is_cmp = 1'b1; end
            OP_JEQ:  begin cls = CL_JUMP;  take = (cc == CC_EQ); end
            OP_JGT:  begin cls = CL_JUMP;  take = (cc == CC_GT); end
            OP_JLT:  begin cls = CL_JUMP;  take = (cc == CC_LT); end
            OP_J:    begin cls = CL_JUMP;  take = 1'b1; end
            OP_JSUB: begin cls = CL_JUMP;  take = 1'b1; link = 1'b1; end
            OP_RSUB: begin cls = CL_JUMP;  ret = 1'b1; end
            OP_TD, OP_RD, OP_WD: cls = CL_DEV;
            default: cls = CL_BAD;
        endcase
    end
endmodule

// File: rtl/acc24_alu.sv
module acc24_alu
    import acc24_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  aluop_e            aop,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y,
    output cc_e               cmp,
    output logic              div_zero
);
    always_comb begin
        div_zero = (b == '0);
        unique case (aop)
            AL_ADD:  y = a + b;
            AL_SUB:  y = a - b;
            AL_MUL:  y = a * b;
            AL_DIV:  y = div_zero ? a : WORD_W'($signed(a) / $signed(b));
            default: y = b;
        endcase
        if ($signed(a) < $signed(b))
            cmp = CC_LT;
        else if (a == b)
            cmp = CC_EQ;
        else
            cmp = CC_GT;
    end
endmodule

// File: rtl/acc24_cpu.sv
module acc24_cpu
    import acc24_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [BYTE_W-1:0] dev_code,
    input  logic              dev_ready,
    input  logic [BYTE_W-1:0] dev_rdata,
    output logic [BYTE_W-1:0] dev_wdata,
    output logic              dev_rd_stb,
    output logic              dev_wr_stb,
    output logic              halted
);
    localparam int              NB    = WORD_W / BYTE_W;
    localparam int              BC_W  = $clog2(NB);
    localparam logic [BC_W-1:0] LAST  = BC_W'(NB - 1);
    localparam int              XBIT  = ADDR_W;

    state_e            st, st_nx;
    logic [BC_W-1:0]   bc;
    logic [WORD_W-1:0] ir, opnd, reg_a, reg_x;
    logic [ADDR_W-1:0] pc, ta, reg_l, ta_calc;
    cc_e               cc;

    opclass_e          cls;
    aluop_e            aop;
    logic              sel_x, is_cmp, take, link, ret;
    logic [WORD_W-1:0] alu_y, store_word;
    cc_e               alu_cmp;
    logic              div_zero, byte_last;
    logic [BYTE_W-1:0] opc;

    assign opc        = ir[WORD_W-1 -: BYTE_W];
    assign byte_last  = (bc == LAST);
    assign ta_calc    = ir[ADDR_W-1:0] + (ir[XBIT] ? reg_x[ADDR_W-1:0] : '0);
    assign store_word = sel_x ? reg_x : reg_a;

    acc24_decode #(.OPC_W(BYTE_W)) u_dec (
        .opc(opc), .cc(cc), .cls(cls), .aop(aop), .sel_x(sel_x),
        .is_cmp(is_cmp), .take(take), .link(link), .ret(ret)
    );

    acc24_alu #(.WORD_W(WORD_W)) u_alu (
        .aop(aop), .a(reg_a), .b(opnd), .y(alu_y), .cmp(alu_cmp), .div_zero(div_zero)
    );

    // next-state selection
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_FETCH:  if (byte_last) st_nx = ST_DECODE;
            ST_DECODE: begin
                unique case (cls)
                    CL_LOAD:  st_nx = ST_LOADW;
                    CL_STORE: st_nx = ST_STOREW;
                    CL_JUMP:  st_nx = ST_FETCH;
                    CL_DEV:   st_nx = ST_DEVIO;
                    default:  st_nx = ST_HALT;
                endcase
            end
            ST_LOADW:  if (byte_last) st_nx = ST_APPLY;
            ST_APPLY:  st_nx = (aop == AL_DIV && div_zero) ? ST_HALT : ST_FETCH;
            ST_STOREW: if (byte_last) st_nx = ST_FETCH;
            ST_DEVIO:  st_nx = ST_FETCH;
            default:   st_nx = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_FETCH;
        else        st <= st_nx;
    end

    // outputs
    always_comb begin
        mem_addr   = pc + ADDR_W'(bc);
        mem_wdata  = '0;
        mem_we     = 1'b0;
        dev_code   = '0;
        dev_wdata  = reg_a[BYTE_W-1:0];
        dev_rd_stb = 1'b0;
        dev_wr_stb = 1'b0;
        halted     = 1'b0;
        unique case (st)
            ST_LOADW:  mem_addr = ta + ADDR_W'(bc);
            ST_STOREW: begin
                mem_addr  = ta + ADDR_W'(bc);
                mem_we    = 1'b1;
                mem_wdata = store_word[(NB - 1 - int'(bc)) * BYTE_W +: BYTE_W];
            end
            ST_DEVIO: begin
                mem_addr   = ta;
                dev_code   = mem_rdata;
                dev_rd_stb = (opc == OP_RD);
                dev_wr_stb = (opc == OP_WD);
            end
            ST_HALT:   halted = 1'b1;
            default:   ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc    <= '0;
            ir    <= '0;
            opnd  <= '0;
            reg_a <= '0;
            reg_x <= '0;
            reg_l <= '0;
            pc    <= '0;
            ta    <= '0;
            cc    <= CC_EQ;
        end else begin
            unique case (st)
                ST_FETCH: begin
                    ir <= {ir[WORD_W-BYTE_W-1:0], mem_rdata};
                    bc <= byte_last ? '0 : bc + 1'b1;
                    if (byte_last) pc <= pc + ADDR_W'(NB);
                end
                ST_DECODE: begin
                    ta <= ta_calc;
                    if (cls == CL_JUMP) begin
                        if (ret)       pc <= reg_l;
                        else if (take) pc <= ta_calc;
                        if (link)      reg_l <= pc;
                    end
                end
                ST_LOADW: begin
                    opnd <= {opnd[WORD_W-BYTE_W-1:0], mem_rdata};
                    bc   <= byte_last ? '0 : bc + 1'b1;
                end
                ST_APPLY: begin
                    if (is_cmp)
                        cc <= alu_cmp;
                    else if (!(aop == AL_DIV && div_zero)) begin
                        if (sel_x) reg_x <= alu_y;
                        else       reg_a <= alu_y;
                    end
                end
                ST_STOREW: bc <= byte_last ? '0 : bc + 1'b1;
                ST_DEVIO: begin
                    if (opc == OP_TD) cc <= dev_ready ? CC_LT : CC_EQ;
                    if (opc == OP_RD) reg_a[BYTE_W-1:0] <= dev_rdata;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/acc24_cpu_chk.sv
module acc24_cpu_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              dev_rd_stb,
    input logic              dev_wr_stb,
    input logic              halted
);
    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_we && !dev_rd_stb && !dev_wr_stb));

    // R4
    store_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |=> mem_we);

    // R4
    store_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr_stb |=> !dev_wr_stb);

    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd_stb |=> !dev_rd_stb);

    // R10
    stb_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd_stb || dev_wr_stb) |-> !mem_we);
endmodule

bind acc24_cpu acc24_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb), .halted(halted)
);

// File: tb/tb_acc24_cpu.sv
module tb_acc24_cpu;
    localparam logic [7:0] LDA = 8'h00, LDX = 8'h04, STA = 8'h0C, STX = 8'h10,
                           ADD = 8'h18, SUB = 8'h1C, MUL = 8'h20, DIV = 8'h24,
                           COMP = 8'h28, JEQ = 8'h30, JGT = 8'h34, JLT = 8'h38,
                           JMP = 8'h3C, JSUB = 8'h48, RSUB = 8'h4C,
                           RD = 8'hD8, WD = 8'hDC, TD = 8'hE0, BAD = 8'hFF;
    localparam logic [23:0] FILL = 24'h5A5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata, dev_code, dev_rdata, dev_wdata;
    logic        mem_we, dev_ready, dev_rd_stb, dev_wr_stb, halted;

    logic [7:0]  mem [0:4095];
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;

    int cyc = 0, gcyc = 0, ready_at = 0;
    int wr_cnt = 0, rd_cnt = 0, wr_cyc = 0;
    logic [7:0] wr_byte = '0, wr_code = '0, rd_code = '0;
    int nchk = 0, nfail = 0;

    always #2 clk = ~clk;

    acc24_cpu dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .dev_code(dev_code),
        .dev_ready(dev_ready), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
        .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb), .halted(halted)
    );

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end
    assign mem_rdata = mem[mem_addr[11:0]];

    assign dev_ready = (cyc >= ready_at);
    assign dev_rdata = (dev_code == 8'h05) ? 8'hC3 : 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 0; wr_cnt <= 0; rd_cnt <= 0;
        end else begin
            cyc <= cyc + 1;
            if (dev_wr_stb) begin
                wr_cnt <= wr_cnt + 1; wr_byte <= dev_wdata;
                wr_code <= dev_code; wr_cyc <= cyc;
            end
            if (dev_rd_stb) begin
                rd_cnt <= rd_cnt + 1; rd_code <= dev_code;
            end
        end
    end

    always @(posedge clk) begin
        gcyc = gcyc + 1;
        if (gcyc == 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", gcyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a[11:0]; ld_data = d;
    endtask

    task automatic pokew(input int a, input logic [23:0] w);
        poke(a, w[23:16]); poke(a + 1, w[15:8]); poke(a + 2, w[7:0]);
    endtask

    task automatic ins(input int a, input logic [7:0] op, input bit x, input int t);
        pokew(a, {op, x, t[14:0]});
    endtask

    function automatic logic [23:0] peekw(input int a);
        return {mem[a], mem[a + 1], mem[a + 2]};
    endfunction

    task automatic hold_reset();
        @(negedge clk); rst_n = 1'b0;
    endtask

    task automatic run(input int limit);
        @(negedge clk); ld_en = 1'b0; rst_n = 1'b1;
        for (int i = 0; i < limit && !halted; i++) @(negedge clk);
    endtask

    function automatic logic [23:0] val(input int i);
        case (i)
            0: return 24'd0;
            1: return 24'd1;
            2: return -24'sd1;
            3: return 24'd5;
            4: return -24'sd37;
            5: return 24'd1000;
            6: return -24'sd8388607;
            default: return 24'd8388607;
        endcase
    endfunction

    task automatic load_arith();
        ins(0, LDA, 0, 'h300);  ins(3, ADD, 0, 'h303);  ins(6, STA, 0, 'h310);
        ins(9, LDA, 0, 'h300);  ins(12, SUB, 0, 'h303); ins(15, STA, 0, 'h313);
        ins(18, LDA, 0, 'h300); ins(21, MUL, 0, 'h303); ins(24, STA, 0, 'h316);
        ins(27, LDA, 0, 'h300); ins(30, COMP, 0, 'h303);
        ins(33, JLT, 0, 45); ins(36, JEQ, 0, 51); ins(39, JGT, 0, 57);
        ins(42, JMP, 0, 60);
        ins(45, LDA, 0, 'h320); ins(48, JMP, 0, 60);
        ins(51, LDA, 0, 'h323); ins(54, JMP, 0, 60);
        ins(57, LDA, 0, 'h326);
        ins(60, STA, 0, 'h319);
        ins(63, LDA, 0, 'h300); ins(66, DIV, 0, 'h303); ins(69, STA, 0, 'h31C);
        ins(72, BAD, 0, 0);
        pokew('h320, 24'h111111); pokew('h323, 24'h222222); pokew('h326, 24'h333333);
    endtask

    task automatic main_prog(input int rdy, input logic [23:0] sum);
        logic [23:0] got;
        hold_reset();
        ready_at = rdy;
        ins(0, LDX, 0, 'h500);  ins(3, JSUB, 0, 'h100); ins(6, STA, 0, 'h510);
        ins(9, STX, 0, 'h513);  ins(12, TD, 0, 'h520);  ins(15, JEQ, 0, 12);
        ins(18, WD, 0, 'h520);  ins(21, RD, 0, 'h520);  ins(24, STA, 0, 'h516);
        ins(27, BAD, 0, 0);     ins(30, STA, 0, 'h540);
        ins('h100, LDA, 0, 'h500); ins('h103, STA, 0, 'h530);
        ins('h106, LDA, 0, 'h530); ins('h109, ADD, 1, 'h400); ins('h10C, STA, 0, 'h530);
        ins('h10F, STX, 0, 'h533); ins('h112, LDA, 0, 'h533); ins('h115, ADD, 0, 'h503);
        ins('h118, STA, 0, 'h533); ins('h11B, LDX, 0, 'h533); ins('h11E, COMP, 0, 'h506);
        ins('h121, JLT, 0, 'h106); ins('h124, LDA, 0, 'h530); ins('h127, RSUB, 0, 0);
        pokew('h400, 24'd100); pokew('h403, -24'sd3); pokew('h406, 24'd70000);
        pokew('h409, 24'd12345);
        pokew('h500, 24'd0); pokew('h503, 24'd3); pokew('h506, 24'd12);
        poke('h520, 8'h05);
        pokew('h510, FILL); pokew('h513, FILL); pokew('h516, FILL); pokew('h540, FILL);
        // R1: state while reset held
        @(negedge clk);
        check(mem_addr == 0 && !mem_we && !halted && !dev_rd_stb && !dev_wr_stb,
              "R1", "reset outputs", {mem_addr, mem_we, halted, dev_wr_stb}, 24'd0);
        // R2: first fetch walks 0,1,2
        ld_en = 1'b0; rst_n = 1'b1;
        check(mem_addr == 0, "R2", "fetch byte 0", 24'(mem_addr), 24'd0);
        @(negedge clk);
        check(mem_addr == 1, "R2", "fetch byte 1", 24'(mem_addr), 24'd1);
        @(negedge clk);
        check(mem_addr == 2, "R2", "fetch byte 2", 24'(mem_addr), 24'd2);
        for (int i = 0; i < 5000 && !halted; i++) @(negedge clk);
        check(halted == 1'b1, "R11", "halt on unknown opcode", 24'(halted), 24'd1);
        got = peekw('h510);
        check(got == sum, "R3", "indexed sum via subroutine", got, sum);
        got = peekw('h513);
        check(got == 24'd12, "R4", "STX of final index", got, 24'd12);
        check(wr_cnt == 1 && wr_byte == sum[7:0], "R10", "WD byte",
              {wr_cnt[7:0], 8'h00, wr_byte}, {8'd1, 8'h00, sum[7:0]});
        check(wr_code == 8'h05 && rd_code == 8'h05 && rd_cnt == 1, "R10", "device code",
              {rd_cnt[7:0], rd_code, wr_code}, {8'd1, 8'h05, 8'h05});
        got = peekw('h516);
        check(got == {sum[23:8], 8'hC3}, "R10", "RD into low byte", got, {sum[23:8], 8'hC3});
        check(got[23:8] == sum[23:8], "R8", "RSUB returned with sum in A",
              {8'h0, got[23:8]}, {8'h0, sum[23:8]});
        if (rdy == 0)
            check(wr_cyc < 600, "R9", "TD ready gives less, no polling",
                  24'(wr_cyc), 24'd600);
        else
            check(wr_cyc >= rdy, "R9", "TD not ready gives equal, polls",
                  24'(wr_cyc), 24'(rdy));
        repeat (20) @(negedge clk);
        check(halted && wr_cnt == 1 && !mem_we, "R11", "quiet after halt",
              {halted, 15'd0, wr_cnt[7:0]}, {1'b1, 15'd0, 8'd1});
        got = peekw('h540);
        check(got == FILL, "R11", "no store after halt", got, FILL);
    endtask

    initial begin
        logic [23:0] sum;
        sum = 24'd100 - 24'd3 + 24'd70000 + 24'd12345;
        main_prog(0, sum);
        main_prog(600, sum);
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [23:0] a, b, got, exp;
                longint pa, pb, q;
                a = val(i); b = val(j);
                pa = longint'($signed(a)); pb = longint'($signed(b));
                hold_reset();
                load_arith();
                pokew('h300, a); pokew('h303, b);
                pokew('h310, FILL); pokew('h313, FILL); pokew('h316, FILL);
                pokew('h319, FILL); pokew('h31C, FILL);
                run(3000);
                check(halted, "R6", "run ends halted", 24'(halted), 24'd1);
                exp = 24'(pa + pb); got = peekw('h310);
                check(got == exp, "R5", "ADD", got, exp);
                exp = 24'(pa - pb); got = peekw('h313);
                check(got == exp, "R5", "SUB", got, exp);
                exp = 24'(pa * pb); got = peekw('h316);
                check(got == exp, "R5", "MUL", got, exp);
                exp = (pa < pb) ? 24'h111111 : (pa == pb) ? 24'h222222 : 24'h333333;
                got = peekw('h319);
                check(got == exp, "R7", "COMP and conditional jump", got, exp);
                if (pb == 0) exp = FILL;
                else begin q = pa / pb; exp = 24'(q); end
                got = peekw('h31C);
                check(got == exp, "R6", "DIV quotient or zero-divisor halt", got, exp);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule